// File: doc/BRIEF.md
# DMA Interrupt Status and Control Register

This block is the 32-bit interrupt control and status word of a seven-channel DMA controller. Software writes it to set per-channel interrupt enables, a master enable, a force bit and six general-purpose bits. The channel engines report finished transfers as single-cycle pulses. Each pulse raises that channel's completion flag, but only when the channel's enable is set. Software clears a flag by writing 1 to its bit.

A two-state machine holds the summary "request sent" bit. In `IRQ_QUIET` the summary bit reads 0. The `QUIET_TO_RAISED` transition happens when the interrupt condition becomes true: the force bit is set, or the master enable is set and at least one completion flag is set. On that transition the block emits a one-cycle request to line 3 of the system interrupt controller. In `IRQ_RAISED` the summary bit reads 1. While the condition stays true, the `RAISED_HOLD` transition keeps the state and emits no further request. The `RAISED_TO_QUIET` transition happens as soon as the condition goes false, and this re-arms the edge. In `IRQ_QUIET`, the `QUIET_HOLD` transition keeps the state while the condition is false. Since a request is sent only on entry to `IRQ_RAISED`, the output behaves as an edge, not a level.

The condition is evaluated on every update: on each CPU write and on each completion pulse. It uses the register contents that this update produces.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x00000000 and `irq_pulse` is low.
- R2: A write stores only the bits under mask 0x00FF803F. These are bits 5:0 (general-purpose storage), bit 15 (force), bits 22:16 (enable of channel 0..6, where bit 16 is channel 0) and bit 23 (master enable). Written values appear on `rd_data` in the cycle after the write.
- R3: Bits 14:6 always read 0. A write cannot set a completion flag (bits 30:24) or the summary bit (bit 31).
- R4: A pulse on `done[i]` sets flag bit 24+i only if enable bit 16+i is set before that cycle's update.
- R5: Writing 1 to flag bit 24+i clears that flag. Writing 0 leaves it unchanged.
- R6: When the master enable is set and any flag is set, bit 31 becomes 1. If bit 31 was 0 before the update, `irq_pulse` is high for that cycle. With the master enable clear, flags alone do not raise bit 31.
- R7: The force bit alone sets bit 31 and pulses `irq_pulse` on its rising update, whatever the master enable and flags hold.
- R8: While bit 31 is already 1, further updates that keep the condition true produce no pulse.
- R9: Bit 31 returns to 0 in the cycle after the condition becomes false. A later rise of the condition pulses `irq_pulse` again.
- R10: If a write clears flag i in the same cycle that `done[i]` sets it, the flag ends up set.
- R11: `irq_pulse` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe for this register |
| wr_data | input | 32 | CPU write data |
| done | input | 7 | Per-channel transfer-complete pulses |
| rd_data | output | 32 | Current register value |
| irq_pulse | output | 1 | One-cycle request to system interrupt line 3 |

## Verification
Two events can fall in the same cycle: a CPU write that clears a channel's flag, and that channel's completion pulse. The bench provokes this by driving `wr_en`, the write-1 to the flag bit and `done` in one cycle. It judges the result by the flag reading as set afterwards and by no second request appearing, because the summary bit was already set. A completion pulse arriving in the same cycle as a write that enables the channel is also exercised. It must not set the flag, because the enable in force before the update governs.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
    localparam int NUM_CH     = 7;
    localparam int REG_W      = 32;
    localparam int GP_W       = 6;
    localparam int FORCE_BIT  = 15;
    localparam int EN_LO      = 16;
    localparam int MASTER_BIT = EN_LO + NUM_CH;
    localparam int FLAG_LO    = MASTER_BIT + 1;
    localparam int SENT_BIT   = FLAG_LO + NUM_CH;
    localparam int ZERO_W     = FORCE_BIT - GP_W;

    typedef enum logic {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/dicr_fields.sv
module dicr_fields
    import dicr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [GP_W-1:0]   gp_q,
    output logic              force_q,
    output logic              force_nxt,
    output logic [NUM_CH-1:0] en_q,
    output logic              master_q,
    output logic              master_nxt
);
    logic [GP_W-1:0]   gp_nxt;
    logic [NUM_CH-1:0] en_nxt;

    always_comb begin
        gp_nxt     = wr_en ? wr_data[GP_W-1:0]               : gp_q;
        force_nxt  = wr_en ? wr_data[FORCE_BIT]              : force_q;
        en_nxt     = wr_en ? wr_data[EN_LO +: NUM_CH]        : en_q;
        master_nxt = wr_en ? wr_data[MASTER_BIT]             : master_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gp_q     <= '0;
            force_q  <= 1'b0;
            en_q     <= '0;
            master_q <= 1'b0;
        end else begin
            gp_q     <= gp_nxt;
            force_q  <= force_nxt;
            en_q     <= en_nxt;
            master_q <= master_nxt;
        end
    end
endmodule

// File: rtl/dicr_flags.sv
module dicr_flags
    import dicr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [NUM_CH-1:0] clr_bits,
    input  logic [NUM_CH-1:0] done,
    input  logic [NUM_CH-1:0] en_q,
    output logic [NUM_CH-1:0] flag_q,
    output logic [NUM_CH-1:0] flag_nxt
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic set_c;
        logic clr_c;

        // Completion is applied after the clear, so a same-cycle pulse wins.
        assign set_c        = done[ch] & en_q[ch];
        assign clr_c        = wr_en & clr_bits[ch];
        assign flag_nxt[ch] = set_c | (flag_q[ch] & ~clr_c);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[ch] <= 1'b0;
            else        flag_q[ch] <= flag_nxt[ch];
        end
    end
endmodule

// File: rtl/dicr_irq_fsm.sv
module dicr_irq_fsm
    import dicr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_nxt,
    output logic sent,
    output logic irq_pulse
);
    irq_state_e state_q;
    irq_state_e state_d;
    logic       pulse_d;

    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        unique case (state_q)
            IRQ_QUIET: begin
                if (cond_nxt) begin
                    state_d = IRQ_RAISED;
                    pulse_d = 1'b1;
                end
            end
            IRQ_RAISED: begin
                if (!cond_nxt) state_d = IRQ_QUIET;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_pulse <= 1'b0;
        else        irq_pulse <= pulse_d;
    end

    assign sent = (state_q == IRQ_RAISED);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dicr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [NUM_CH-1:0] done,
    output logic [REG_W-1:0]  rd_data,
    output logic              irq_pulse
);
    logic [GP_W-1:0]   gp_q;
    logic              force_q, force_nxt;
    logic [NUM_CH-1:0] en_q;
    logic              master_q, master_nxt;
    logic [NUM_CH-1:0] flag_q, flag_nxt;
    logic              cond_nxt;
    logic              sent;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[SENT_BIT], wr_data[FORCE_BIT-1:GP_W]};

    dicr_fields u_fields (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .gp_q       (gp_q),
        .force_q    (force_q),
        .force_nxt  (force_nxt),
        .en_q       (en_q),
        .master_q   (master_q),
        .master_nxt (master_nxt)
    );

    dicr_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .clr_bits (wr_data[FLAG_LO +: NUM_CH]),
        .done     (done),
        .en_q     (en_q),
        .flag_q   (flag_q),
        .flag_nxt (flag_nxt)
    );

    assign cond_nxt = (master_nxt & (|flag_nxt)) | force_nxt;

    dicr_irq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cond_nxt  (cond_nxt),
        .sent      (sent),
        .irq_pulse (irq_pulse)
    );

    assign rd_data = {sent, flag_q, master_q, en_q, force_q, {ZERO_W{1'b0}}, gp_q};
endmodule

// File: rtl/dma_irq_ctrl_chk.sv
module dma_irq_ctrl_chk
    import dicr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [NUM_CH-1:0]   wr_clr,
    input logic [NUM_CH-1:0]   done,
    input logic [REG_W-1:FORCE_BIT] rd_hi,
    input logic                irq_pulse
);
    logic              sent_b, master_b, force_b;
    logic [NUM_CH-1:0] flags_b, en_b;

    assign sent_b   = rd_hi[SENT_BIT];
    assign flags_b  = rd_hi[FLAG_LO +: NUM_CH];
    assign master_b = rd_hi[MASTER_BIT];
    assign en_b     = rd_hi[EN_LO +: NUM_CH];
    assign force_b  = rd_hi[FORCE_BIT];

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    assert_pulse_with_sent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> sent_b);

    assert_no_repeat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent_b) |-> irq_pulse);

    assert_sent_needs_cond_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sent_b |-> ((master_b && (|flags_b)) || force_b));

    assert_cond_sets_sent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((master_b && (|flags_b)) || force_b) |-> sent_b);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
        assert_flag_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags_b[ch]) |-> ($past(done[ch]) && $past(en_b[ch])));

        assert_flag_clear_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flags_b[ch]) |-> ($past(wr_en) && $past(wr_clr[ch]) && !$past(done[ch])));
    end
endmodule

bind dma_irq_ctrl dma_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_clr    (wr_data[dicr_pkg::FLAG_LO +: dicr_pkg::NUM_CH]),
    .done      (done),
    .rd_hi     (rd_data[dicr_pkg::REG_W-1:dicr_pkg::FORCE_BIT]),
    .irq_pulse (irq_pulse)
);

// File: tb/sim_dma_irq_ctrl.sv
module sim_dma_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    typedef struct {
        logic [31:0] rd;
        logic        irq;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [6:0]  done = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int checks = 0;
    int errors = 0;
    bit driver_done = 1'b0;
    exp_t exp_q[$];

    // Reference state built from the requirements
    logic [5:0] m_gp = '0;
    logic       m_force = 1'b0;
    logic [6:0] m_en = '0;
    logic       m_master = 1'b0;
    logic [6:0] m_flags = '0;
    logic       m_sent = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .done      (done),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    task automatic step(input logic w, input logic [31:0] d, input logic [6:0] dn, input string tag);
        exp_t e;
        logic [6:0] nflags;
        logic cond;
        @(negedge clk);
        wr_en = w; wr_data = d; done = dn;
        nflags = (m_flags & ~(w ? d[30:24] : 7'h0)) | (dn & m_en);
        if (w) begin
            m_gp = d[5:0]; m_force = d[15]; m_en = d[22:16]; m_master = d[23];
        end
        m_flags = nflags;
        cond = (m_master && (|m_flags)) || m_force;
        e.irq = cond && !m_sent;
        m_sent = cond;
        e.rd = {m_sent, m_flags, m_master, m_en, m_force, 9'b0, m_gp};
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (rd_data !== e.rd || irq_pulse !== e.irq) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                             e.tag, rd_data, irq_pulse, e.rd, e.irq);
                end
            end
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/4);
        checks++;
        if (rd_data !== 32'h0 || irq_pulse !== 1'b0) begin
            errors++;
            $display("FAIL R1: rd_data=%h irq=%b expected rd_data=00000000 irq=0", rd_data, irq_pulse);
        end
        @(negedge clk); rst_n = 1'b1;

        step(1, 32'h0004_0000, 7'h00, "R2 enable ch2");
        step(0, 32'h0,         7'h05, "R4 ch0 masked ch2 set");
        step(1, 32'h0084_0005, 7'h00, "R6 master raises request");
        step(0, 32'h0,         7'h00, "R11 pulse ends");
        step(1, 32'h00A4_0005, 7'h00, "R8 enable ch5 no pulse");
        step(0, 32'h0,         7'h20, "R8 ch5 completes no pulse");
        step(1, 32'h04A4_0005, 7'h00, "R5 clear ch2 keep ch5");
        step(1, 32'h20A4_0005, 7'h00, "R9 all clear drops summary");
        step(0, 32'h0,         7'h04, "R9 re-raise pulses");
        step(1, 32'h04A4_0005, 7'h04, "R10 clear and set same cycle");
        step(1, 32'h04A4_0005, 7'h00, "R5 clear ch2");
        step(1, 32'hFFFF_FFFF, 7'h00, "R2 mask all ones");
        step(1, 32'h0000_8000, 7'h00, "R7 force keeps summary");
        step(1, 32'h0000_0000, 7'h00, "R9 all off");
        step(1, 32'h0000_8000, 7'h00, "R7 force alone pulses");
        step(1, 32'h0000_7FC0, 7'h00, "R3 bits 14:6 read zero");
        step(1, 32'h007F_0000, 7'h7F, "R4 enable same cycle not used");
        step(0, 32'h0,         7'h7F, "R6 flags without master");
        step(1, 32'h00FF_0000, 7'h00, "R6 master on with flags");
        step(1, 32'h7FFF_0000, 7'h00, "R5 clear all flags");
        step(0, 32'h0,         7'h00, "R11 idle");

        @(negedge clk); wr_en = 0; done = '0;
        repeat (3) @(posedge clk);
        driver_done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (driver_done);
            begin
                repeat (WATCHDOG) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule